// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block turns a fast system clock into the serial clock timing for an I2C master. The input clock passes through two cascaded programmable prescalers, a 2-bit stage A and a 6-bit stage B. Each output pulse of stage B advances a step counter that runs from 0 to 21, and 22 steps make one SCL period. A bit engine next to this block consumes the SCL level, a tick stream marking four points in each period, and a flag that reports when a slave holds the clock low.

The divisor fields arrive as the upper byte of a control word. The generator copies them into working registers only at a period boundary, so a write in the middle of a period never shortens or lengthens a half-cycle. When SCL is released but the line reads back low, the step counter waits until the line is seen high. One SCL period lasts 22 × (A+1) × (B+1) input cycles. With a 100 MHz input, for example, A=1 and B=5 give 100e6 / 264 ≈ 379 kHz, which is below the 400 kHz ceiling. Choosing the divisors is left to software.

Top module: `scl_rate_gen`

## Requirements
- R1: `ctrl_hi` carries control-word bits 15:8. Divisor A is `ctrl_hi[7:6]` and divisor B is `ctrl_hi[5:0]`. Every step lasts (A+1)×(B+1) input cycles, so an unstretched SCL period lasts 22×(A+1)×(B+1) cycles.
- R2: After enable, `scl_o` is low for steps 0–10 and high for steps 11–21. Each half therefore lasts 11×(A+1)×(B+1) cycles, and the low half comes first.
- R3: `tick_o` pulses for one cycle in the first cycle of steps 0, 5, 11 and 16. `phase_o` reads 0, 1, 2 and 3 at those ticks. The tick with phase 2 falls in the first cycle of SCL high, and the tick with phase 0 falls in the first cycle of SCL low.
- R4: While `scl_o` is high (steps 11–21) and `scl_in` reads low, `stretch_o` is 1, the step counter holds, `scl_o` stays high and no tick is issued. A low `scl_in` during steps 0–10 has no effect: `stretch_o` stays 0 and the low half keeps its length.
- R5: A new `ctrl_hi` value takes effect only when step 21 wraps to step 0. The half-period in progress keeps the old divisors, including when that half-period is stretched.
- R6: With `en` low, from the next cycle on `scl_o` is 1, `tick_o` is 0 and `stretch_o` is 0. The cycle after `en` is sampled high starts step 0, with `scl_o` low and a phase-0 tick.
- R7: During reset, `scl_o` is 1 and both `tick_o` and `stretch_o` are 0.
- R8: Both divisor extremes are honoured. A=0, B=0 gives 11-cycle halves, and A=3, B=63 gives 2816-cycle halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Synchronous run enable; low parks SCL high and clears all counters |
| ctrl_hi | input | 8 | Control-word bits 15:8: divisor A in [7:6], divisor B in [5:0] |
| scl_in | input | 1 | SCL level read back from the bus |
| scl_o | output | 1 | SCL level to drive: 0 pulls low, 1 releases |
| tick_o | output | 1 | One-cycle pulse at steps 0, 5, 11 and 16 |
| phase_o | output | 2 | Index of the most recent tick point (0..3) |
| stretch_o | output | 1 | SCL released but read back low |

## Verification
A divisor reload and a clock stretch can both act at the period boundary. A stretch freezes the step counter, and the reload waits for the step counter to wrap. To force the two together, the bench writes new divisors at the first cycle of SCL high and, in the same cycle, pulls the read-back line low for longer than a half-period. It then checks three things: SCL stays high for the whole hold, the rest of that high half ends within the old half-length, and the following low half has exactly the new length.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  localparam int STEPS      = 22;
  localparam int HALF_STEPS = 11;
  localparam int MID_LOW    = 5;
  localparam int MID_HIGH   = 16;

  typedef enum logic [1:0] {
    PH_FALL     = 2'd0,
    PH_LOW_MID  = 2'd1,
    PH_RISE     = 2'd2,
    PH_HIGH_MID = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         strobe
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    strobe = run && step && (cnt_q == limit);
    cnt_d  = cnt_q;
    if (!run)        cnt_d = '0;
    else if (strobe) cnt_d = '0;
    else if (step)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit); // R1
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter
  import scl_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       step,
  input  logic       scl_in,
  output logic       go,
  output logic       wrap,
  output logic       scl_o,
  output logic       tick_o,
  output logic [1:0] phase_o,
  output logic       stretch_o
);
  localparam int CW = $clog2(STEPS);
  localparam logic [CW-1:0] LAST  = CW'(STEPS - 1);
  localparam logic [CW-1:0] HALF  = CW'(HALF_STEPS);
  localparam logic [CW-1:0] QLOW  = CW'(MID_LOW);
  localparam logic [CW-1:0] QHIGH = CW'(MID_HIGH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, tick_q, tick_d;
  phase_e        phase_q, phase_d;
  logic          hold, adv;

  always_comb begin
    go      = en && run_q;
    hold    = run_q && (cnt_q >= HALF) && !scl_in;
    adv     = go && step && !hold;
    wrap    = adv && (cnt_q == LAST);
    cnt_d   = cnt_q;
    tick_d  = 1'b0;
    phase_d = phase_q;
    if (!en) begin
      cnt_d   = '0;
      phase_d = PH_FALL;
    end else if (!run_q) begin
      cnt_d   = '0;
      tick_d  = 1'b1;
      phase_d = PH_FALL;
    end else if (adv) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
      if (cnt_d == '0) begin
        tick_d = 1'b1; phase_d = PH_FALL;
      end else if (cnt_d == QLOW) begin
        tick_d = 1'b1; phase_d = PH_LOW_MID;
      end else if (cnt_d == HALF) begin
        tick_d = 1'b1; phase_d = PH_RISE;
      end else if (cnt_d == QHIGH) begin
        tick_d = 1'b1; phase_d = PH_HIGH_MID;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      tick_q  <= 1'b0;
      phase_q <= PH_FALL;
    end else begin
      cnt_q   <= cnt_d;
      run_q   <= en;
      tick_q  <= tick_d;
      phase_q <= phase_d;
    end
  end

  assign scl_o     = run_q ? (cnt_q >= HALF) : 1'b1;
  assign tick_o    = tick_q;
  assign phase_o   = phase_q;
  assign stretch_o = hold;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R1
  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch_o && en) |=> ($stable(cnt_q) && scl_o && !tick_o)); // R4
  AST_PARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_o && !tick_o && !stretch_o)); // R6
  AST_TICK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_o) && $past(en)) |-> (tick_o && phase_o == 2'd2)); // R3
  AST_TICK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |-> (tick_o && phase_o == 2'd0)); // R3
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int DIVA_W = 2,
  parameter int DIVB_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [DIVA_W+DIVB_W-1:0] ctrl_hi,
  input  logic                     scl_in,
  output logic                     scl_o,
  output logic                     tick_o,
  output logic [1:0]               phase_o,
  output logic                     stretch_o
);
  localparam int CFG_W = DIVA_W + DIVB_W;

  logic              rst_meta_q, rst_sync_n;
  logic [DIVA_W-1:0] diva_q;
  logic [DIVB_W-1:0] divb_q;
  logic              load;
  logic              go, wrap, strobe_a, strobe_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign load = !en || wrap;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      diva_q <= '0;
      divb_q <= '0;
    end else if (load) begin
      diva_q <= ctrl_hi[CFG_W-1 -: DIVA_W];
      divb_q <= ctrl_hi[DIVB_W-1:0];
    end
  end

  scl_prescaler #(.W(DIVA_W)) u_stage_a (
    .clk(clk), .rst_n(rst_sync_n), .run(go), .step(1'b1),
    .limit(diva_q), .strobe(strobe_a)
  );

  scl_prescaler #(.W(DIVB_W)) u_stage_b (
    .clk(clk), .rst_n(rst_sync_n), .run(go), .step(strobe_a),
    .limit(divb_q), .strobe(strobe_b)
  );

  scl_phase_counter u_phase (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .step(strobe_b),
    .scl_in(scl_in), .go(go), .wrap(wrap), .scl_o(scl_o),
    .tick_o(tick_o), .phase_o(phase_o), .stretch_o(stretch_o)
  );

  AST_RELOAD_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!$stable({diva_q, divb_q}) && $past(en)) |-> (tick_o && phase_o == 2'd0)); // R5
endmodule

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] ctrl_hi = 8'h00;
  logic       force_low = 1'b0;
  logic       scl_in;
  logic       scl_o, tick_o, stretch_o;
  logic [1:0] phase_o;
  int         checks = 0;
  int         errors = 0;
  int         cyc = 0;

  always #4 clk = ~clk;

  assign scl_in = scl_o & ~force_low;

  scl_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ctrl_hi(ctrl_hi), .scl_in(scl_in),
    .scl_o(scl_o), .tick_o(tick_o), .phase_o(phase_o), .stretch_o(stretch_o)
  );

  // {ctrl_hi, expected half-period length in cycles}
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 16'd11},
    {8'h42, 16'd66},
    {8'hC5, 16'd264},
    {8'hBF, 16'd2112},
    {8'h0A, 16'd121},
    {8'hFF, 16'd2816}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_until(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (scl_o !== lvl && n < 20000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, lo, hi;
    logic bad;
    localparam int TICK_GAP [4] = '{30, 36, 30, 36};

    repeat (3) @(negedge clk);
    check(scl_o && !tick_o && !stretch_o, "R7 reset state", {scl_o, tick_o, stretch_o}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: divisor settings and half-period lengths
    for (int i = 0; i < 6; i++) begin
      en = 1'b0;
      ctrl_hi = VEC[i][23:16];
      repeat (2) @(negedge clk);
      check(scl_o === 1'b1, "R6 parked high", scl_o, 1);
      en = 1'b1;
      @(negedge clk);
      check(!scl_o && tick_o && phase_o == 2'd0, "R6 start step0 tick", {scl_o, tick_o, phase_o}, 4'b0100);
      run_until(1'b1, lo);
      check(lo == int'(VEC[i][15:0]), "R2 low half", lo, int'(VEC[i][15:0]));
      check(tick_o && phase_o == 2'd2, "R3 rise tick", {tick_o, phase_o}, 3'b110);
      run_until(1'b0, hi);
      check(lo + hi == 2 * int'(VEC[i][15:0]), (i == 5 || i == 0) ? "R8 extreme period" : "R1 period",
            lo + hi, 2 * int'(VEC[i][15:0]));
      check(tick_o && phase_o == 2'd0, "R3 fall tick", {tick_o, phase_o}, 3'b100);
    end

    // R3 tick spacing with A=1, B=2 (6 cycles per step)
    en = 1'b0;
    ctrl_hi = 8'h42;
    repeat (2) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!tick_o && n < 100);
      check(n == TICK_GAP[k] && phase_o == 2'((k + 1) % 4), "R3 tick gap/phase", n, TICK_GAP[k]);
    end

    // R4 stretch in high half
    run_until(1'b1, n);
    repeat (10) @(negedge clk);
    force_low = 1'b1;
    bad = 1'b0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (!scl_o || !stretch_o || tick_o) bad = 1'b1;
    end
    check(!bad, "R4 held during stretch", bad, 0);
    force_low = 1'b0;
    @(negedge clk);
    check(!stretch_o, "R4 flag clears", stretch_o, 0);
    run_until(1'b0, n);
    check(n <= 66, "R4 resumes after release", n, 66);

    // R4 low read-back during low half is ignored
    force_low = 1'b1;
    bad = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (stretch_o || scl_o) bad = 1'b1;
    end
    force_low = 1'b0;
    check(!bad, "R4 no flag in low half", bad, 0);
    run_until(1'b1, n);
    check(n + 20 == 66, "R4 low half unchanged", n + 20, 66);

    // R5 reload at boundary only
    ctrl_hi = 8'h00;
    run_until(1'b0, n);
    check(n == 66, "R5 old divisor kept", n, 66);
    run_until(1'b1, n);
    check(n == 11, "R5 new divisor used", n, 11);

    // R5 with a stretch in the same half
    ctrl_hi = 8'h42;
    force_low = 1'b1;
    bad = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!scl_o) bad = 1'b1;
    end
    check(!bad, "R5 stretch holds high", bad, 0);
    force_low = 1'b0;
    run_until(1'b0, n);
    check(n <= 11, "R5 old divisor after stretch", n, 11);
    run_until(1'b1, n);
    check(n == 66, "R5 new divisor after stretch", n, 66);

    // R6 disable mid low half
    run_until(1'b0, n);
    repeat (5) @(negedge clk);
    force_low = 1'b1;
    en = 1'b0;
    @(negedge clk);
    check(scl_o && !tick_o && !stretch_o, "R6 disable parks", {scl_o, tick_o, stretch_o}, 3'b100);
    force_low = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule